// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar entirely in binary coded decimal. A one-cycle enable pulse, once per second and in the system clock domain, advances a cascade of counters: seconds, then minutes, hours, day of month together with a free-running weekday, month, and a two-digit year. A century bit flips each time the year wraps. Month lengths and the leap-year rule are computed from the current month and year, so software never corrects the calendar.

A host reads and writes the seven time registers through a small address and data port. While the host holds the access-active input high, the counters stay still, so a multi-register read or write sees one consistent moment. One tick that arrives during the access is kept and applied as soon as the access ends. A stop input holds timekeeping. A voltage-low input marks the stored time as untrustworthy through a flag that only the host can clear.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds (address 0, bits 6:4 tens, 3:0 units) and minutes (address 1, same layout) count 00 to 59 in BCD. Hours (address 2, bits 5:4 tens, 3:0 units) count 00 to 23. Each wrap carries one step into the next field on the same tick.
- R2: The day of month (address 3, bits 5:4 tens) counts from 01. After 30 it returns to 01 in months 04, 06, 09 and 11. After 31 it returns to 01 in the other months except February. Each such wrap advances the month.
- R3: In February the last day is 29 when the BCD year is divisible by 4, year 00 included. Otherwise the last day is 28.
- R4: The month (address 5, bit 4 tens, 3:0 units) wraps from 12 to 01 and advances the year (address 6, 00 to 99). When the year wraps from 99 to 00, the century bit (bit 7 of address 5) is inverted.
- R5: The weekday (address 4, bits 2:0) advances by one on every day wrap and goes from 6 back to 0.
- R6: While acc_active is 1, or in a cycle with wr_en, no counter advances. If one or more ticks arrive during that time, exactly one advance is applied in the first cycle after acc_active falls, and any further ticks are lost.
- R7: Bit 7 of address 0 is the integrity flag. It becomes 1 in the cycle after vlow is seen high. Ticks leave it unchanged. A host write to address 0 loads it from wdata bit 7.
- R8: While stop is 1, ticks have no effect and any pending tick is discarded.
- R9: A write with wr_en loads the addressed register from wdata directly. Bits outside each field read back as 0. Address 7 reads 0.
- R10: After reset the time is 00:00:00, day 01, month 01, weekday 0, year 00, century 0, and the integrity flag is 1 (address 0 reads 80h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle enable, once per second |
| stop | input | 1 | Halts timekeeping and drops any pending tick |
| acc_active | input | 1 | Host transaction in progress; freezes counting |
| vlow | input | 1 | Supply-low indication; sets the integrity flag |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register address, 0 to 6 used |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |

## Verification
A register write and a tick each take effect on the clock edge where they are sampled. Read data follows addr without a register, so every check drives its stimulus half a period before an edge and samples rdata half a period after that edge. A pending tick shows up one edge after acc_active falls, and the bench reads it at the falling edge that follows. Checks made during an access confirm that no value moved earlier. The integrity flag is read one edge after vlow rises.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    RA_SEC  = 3'd0,
    RA_MIN  = 3'd1,
    RA_HOUR = 3'd2,
    RA_DAY  = 3'd3,
    RA_WDAY = 3'd4,
    RA_MON  = 3'd5,
    RA_YEAR = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic       vl;
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hr;
    logic [5:0] day;
    logic [2:0] wd;
    logic       cen;
    logic [4:0] mon;
    logic [7:0] yr;
  } rtc_time_t;

  // BCD increment of a two-digit value; the caller handles the wrap.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Leap test on a BCD year: divisible by 4 depends on tens parity.
  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  // Last day of month m (BCD) in year y (BCD), returned in BCD.
  function automatic logic [5:0] bcd_last_day(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return bcd_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick_gate.sv
module rtc_tick_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic busy,
  input  logic stop,
  output logic adv,
  output logic pend
);

  logic pend_d;

  assign adv = !stop && !busy && (tick || pend);

  always_comb begin
    if (stop)      pend_d = 1'b0;
    else if (busy) pend_d = pend || tick;
    else           pend_d = pend && tick;   // both at once: apply one now, one next
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  p_pend_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stop && busy && tick |=> pend);

  p_stop_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !pend);

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              vlow,
  output rtc_time_t         t_q
);

  logic sec_top, min_top, hr_top, day_top, mon_top, yr_top;
  logic c_sec, c_min, c_hr, c_day, c_mon, c_yr;
  logic [7:0] sec_n, min_n, hr_n, day_n, mon_n, yr_n;

  assign sec_top = (t_q.sec == 7'h59);
  assign min_top = (t_q.min == 7'h59);
  assign hr_top  = (t_q.hr  == 6'h23);
  assign day_top = (t_q.day == bcd_last_day(t_q.mon, t_q.yr));
  assign mon_top = (t_q.mon == 5'h12);
  assign yr_top  = (t_q.yr  == 8'h99);

  // Carry events out of each stage, named for the assertions.
  assign c_sec = adv   && sec_top;
  assign c_min = c_sec && min_top;
  assign c_hr  = c_min && hr_top;
  assign c_day = c_hr  && day_top;
  assign c_mon = c_day && mon_top;
  assign c_yr  = c_mon && yr_top;

  assign sec_n = bcd_inc({1'b0, t_q.sec});
  assign min_n = bcd_inc({1'b0, t_q.min});
  assign hr_n  = bcd_inc({2'b0, t_q.hr});
  assign day_n = bcd_inc({2'b0, t_q.day});
  assign mon_n = bcd_inc({3'b0, t_q.mon});
  assign yr_n  = bcd_inc(t_q.yr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q     <= '0;
      t_q.vl  <= 1'b1;
      t_q.day <= 6'h01;
      t_q.mon <= 5'h01;
    end else begin
      if (wr_en) begin
        case (addr)
          RA_SEC:  begin t_q.sec <= wdata[6:0]; t_q.vl <= wdata[7]; end
          RA_MIN:  t_q.min <= wdata[6:0];
          RA_HOUR: t_q.hr  <= wdata[5:0];
          RA_DAY:  t_q.day <= wdata[5:0];
          RA_WDAY: t_q.wd  <= wdata[2:0];
          RA_MON:  begin t_q.mon <= wdata[4:0]; t_q.cen <= wdata[7]; end
          RA_YEAR: t_q.yr  <= wdata;
          default: ;
        endcase
      end else if (adv) begin
        t_q.sec <= sec_top ? 7'h00 : sec_n[6:0];
        if (c_sec) t_q.min <= min_top ? 7'h00 : min_n[6:0];
        if (c_min) t_q.hr  <= hr_top  ? 6'h00 : hr_n[5:0];
        if (c_hr) begin
          t_q.day <= day_top ? 6'h01 : day_n[5:0];
          t_q.wd  <= (t_q.wd == 3'd6) ? 3'd0 : t_q.wd + 3'd1;
        end
        if (c_day) t_q.mon <= mon_top ? 5'h01 : mon_n[4:0];
        if (c_mon) t_q.yr  <= yr_top  ? 8'h00 : yr_n;
        if (c_yr)  t_q.cen <= !t_q.cen;
      end
      if (vlow) t_q.vl <= 1'b1;
    end
  end

  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wr_en && t_q.sec == 7'h59 |=> t_q.sec == 7'h00);

  p_hour_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    c_min && !wr_en && t_q.hr == 6'h23 |=> t_q.hr == 6'h00);

  p_short_month_r2: assert property (@(posedge clk) disable iff (!rst_n)
    c_hr && !wr_en && t_q.mon == 5'h04 && t_q.day == 6'h30 |=> t_q.day == 6'h01 && t_q.mon == 5'h05);

  p_leap_day_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c_hr && !wr_en && t_q.mon == 5'h02 && t_q.day == 6'h28 && bcd_leap(t_q.yr) |=> t_q.day == 6'h29);

  p_century_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    c_yr && !wr_en |=> t_q.cen != $past(t_q.cen) && t_q.yr == 8'h00);

  p_wday_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    c_hr && !wr_en && t_q.wd == 3'd6 |=> t_q.wd == 3'd0);

  p_vl_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vlow |=> t_q.vl);

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              stop,
  input  logic              acc_active,
  input  logic              vlow,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic      busy;
  logic      adv;
  logic      pend;
  rtc_time_t t_q;

  assign busy = acc_active || wr_en;

  rtc_tick_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .busy  (busy),
    .stop  (stop),
    .adv   (adv),
    .pend  (pend)
  );

  rtc_time_chain u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .vlow  (vlow),
    .t_q   (t_q)
  );

  always_comb begin
    case (addr)
      RA_SEC:  rdata = {t_q.vl, t_q.sec};
      RA_MIN:  rdata = {1'b0, t_q.min};
      RA_HOUR: rdata = {2'b0, t_q.hr};
      RA_DAY:  rdata = {2'b0, t_q.day};
      RA_WDAY: rdata = {5'b0, t_q.wd};
      RA_MON:  rdata = {t_q.cen, 2'b0, t_q.mon};
      RA_YEAR: rdata = t_q.yr;
      default: rdata = '0;
    endcase
  end

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_active && !wr_en && !vlow |=> $stable(t_q));

  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !wr_en && !vlow |=> $stable(t_q));

  p_pend_apply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !busy && !stop |-> adv);

endmodule

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       stop = 1'b0;
  logic       acc_active = 1'b0;
  logic       vlow = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_core dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stop(stop), .acc_active(acc_active),
    .vlow(vlow), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // {sec,min,hr,day,wd,mon,yr} loaded, then the same after one tick.
  localparam logic [111:0] VEC [NVEC] = '{
    {56'h00_00_00_01_00_01_24, 56'h01_00_00_01_00_01_24},
    {56'h59_00_10_05_03_06_24, 56'h00_01_10_05_03_06_24},
    {56'h59_09_10_05_03_06_24, 56'h00_10_10_05_03_06_24},
    {56'h59_59_23_15_06_03_24, 56'h00_00_00_16_00_03_24},
    {56'h59_59_23_30_02_04_24, 56'h00_00_00_01_03_05_24},
    {56'h59_59_23_30_02_12_24, 56'h00_00_00_31_03_12_24},
    {56'h59_59_23_31_01_01_24, 56'h00_00_00_01_02_02_24},
    {56'h59_59_23_28_04_02_23, 56'h00_00_00_01_05_03_23},
    {56'h59_59_23_28_04_02_24, 56'h00_00_00_29_05_02_24},
    {56'h59_59_23_29_05_02_00, 56'h00_00_00_01_06_03_00},
    {56'h59_59_23_31_06_12_99, 56'h00_00_00_01_00_81_00},
    {56'h59_59_23_31_06_92_99, 56'h00_00_00_01_00_01_00},
    {56'h59_59_09_30_01_11_24, 56'h00_00_10_30_01_11_24},
    {56'h59_59_23_28_00_02_12, 56'h00_00_00_29_01_02_12}
  };

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check_reg(input logic [2:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr %0d: actual %02h expected %02h", tag, a, rdata, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check_reg(3'd0, 8'h80, "R10");
    check_reg(3'd1, 8'h00, "R10");
    check_reg(3'd2, 8'h00, "R10");
    check_reg(3'd3, 8'h01, "R10");
    check_reg(3'd4, 8'h00, "R10");
    check_reg(3'd5, 8'h01, "R10");
    check_reg(3'd6, 8'h00, "R10");

    // Vector table: R1 R2 R3 R4 R5 across rollovers
    for (int i = 0; i < NVEC; i++) begin
      acc_active = 1'b1;
      for (int r = 0; r < 7; r++) write_reg(3'(r), VEC[i][111 - 8*r -: 8]);
      @(negedge clk);
      acc_active = 1'b0;
      pulse_tick();
      for (int r = 0; r < 7; r++)
        check_reg(3'(r), VEC[i][55 - 8*r -: 8], $sformatf("R1 R2 R3 R4 R5 vector %0d", i));
    end

    // R6: two ticks during access, one advance after it ends
    acc_active = 1'b1;
    write_reg(3'd0, 8'h10);
    pulse_tick();
    pulse_tick();
    check_reg(3'd0, 8'h10, "R6 frozen");
    acc_active = 1'b0;
    @(negedge clk);
    check_reg(3'd0, 8'h11, "R6 pending applied");
    repeat (3) @(negedge clk);
    check_reg(3'd0, 8'h11, "R6 extra tick lost");

    // R8: stop ignores ticks
    stop = 1'b1;
    pulse_tick();
    pulse_tick();
    check_reg(3'd0, 8'h11, "R8 stop holds");
    // R8: pending tick discarded by stop
    acc_active = 1'b1;
    pulse_tick();
    @(negedge clk);
    acc_active = 1'b0;
    repeat (2) @(negedge clk);
    stop = 1'b0;
    repeat (2) @(negedge clk);
    check_reg(3'd0, 8'h11, "R8 pending dropped");
    pulse_tick();
    check_reg(3'd0, 8'h12, "R8 resumes");

    // R7 integrity flag
    @(negedge clk);
    vlow = 1'b1;
    @(negedge clk);
    vlow = 1'b0;
    check_reg(3'd0, 8'h92, "R7 set");
    pulse_tick();
    check_reg(3'd0, 8'h93, "R7 kept over tick");
    write_reg(3'd0, 8'h05);
    check_reg(3'd0, 8'h05, "R7 cleared by write");

    // R9 unused bits and address 7
    write_reg(3'd2, 8'hFF);
    check_reg(3'd2, 8'h3F, "R9 hours mask");
    write_reg(3'd4, 8'hFF);
    check_reg(3'd4, 8'h07, "R9 weekday mask");
    write_reg(3'd5, 8'hFF);
    check_reg(3'd5, 8'h9F, "R9 month mask");
    write_reg(3'd7, 8'hAA);
    check_reg(3'd7, 8'h00, "R9 address 7");

    summary();
  end

endmodule